// File: doc/BRIEF.md
# Serial Line-Rate Search Sequencer

This block works out the line rate of an incoming serial stream by stepping a receive path through a set of candidate bit-rate settings. Eight settings are numbered 0 (slowest) to 7 (fastest). A per-setting enable mask picks the candidates. After a start pulse the sequencer selects the fastest enabled setting and waits there for a lock indication from the receive path. If none arrives within a programmable dwell, it drops to the next slower enabled setting. Once it has passed the slowest enabled setting, it wraps to the fastest one.

The dwell is a 21-bit interval, supplied as a 5-bit upper part and a 16-bit lower part, times 1024 reference-clock cycles. A 10-bit prescaler feeds a 21-bit tick counter, and both restart whenever the setting changes. When lock arrives, the sequencer holds the current setting and flags it as locked. If lock is later lost, it starts a fresh search from the top. A 2-bit reference-frequency code passes straight through to the receive path: 00 selects 122.88 MHz, 01 selects 153.60 MHz (the usual setting), 11 selects 307.20 MHz, and 10 is reserved.

Top module: `rate_search_seq`

## Requirements
- R1: While reset is held and right after its release, `searching` and `locked` are low and `rate_idx` reads 0.
- R2: In idle, a `start` pulse with a non-zero `rate_en` raises `searching` on the next clock, with `rate_idx` at the highest set bit of `rate_en`.
- R3: With `rate_en` all zeros, `start` is ignored and the block stays idle (`searching` and `locked` low). Clearing `rate_en` during a search or a lock returns the block to idle on the next clock.
- R4: Each setting is held for exactly max(I,1) × 1024 clock cycles while searching, where I = {`ivl_hi`,`ivl_lo`} and `ivl_hi` supplies interval bits 20:16.
- R5: On a dwell timeout the block moves to the next lower index whose `rate_en` bit is set, and it spends no time on cleared bits.
- R6: After a timeout at the lowest enabled index, the search wraps to the highest enabled index.
- R7: If `lock_in` is high while searching, then on the next clock `locked` rises, `searching` falls, and `rate_idx` keeps its value for as long as lock stays high.
- R8: If `lock_in` falls while locked, then on the next clock `searching` rises at the highest enabled index and a full new dwell begins.
- R9: `ref_sel_out` equals `ref_sel_in` at all times, for all four codes including the reserved code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a search from idle |
| rate_en | input | 8 | Per-setting enable, bit 7 fastest, bit 0 slowest |
| ivl_hi | input | 5 | Dwell interval bits 20:16 |
| ivl_lo | input | 16 | Dwell interval bits 15:0 |
| ref_sel_in | input | 2 | Reference-frequency code |
| lock_in | input | 1 | Lock indication from the receive path |
| ref_sel_out | output | 2 | Reference-frequency code passed through |
| rate_idx | output | 3 | Current rate setting index |
| searching | output | 1 | A search is in progress |
| locked | output | 1 | Lock held at `rate_idx` |

## Verification
The bench uses a sparse mask (bits 7, 5 and 2) so that it can see disabled settings being skipped and the wrap back to the top. A sequencer that counted down through every index, or stopped at the bottom, would move to the wrong index. A zero interval must still give 1024 cycles, and a wrong guard on the count would give zero or a wrapped count instead. An interval made only of upper bits must not time out within a few thousand cycles, which catches a design that drops `ivl_hi`. The bench also drops lock and checks that the search restarts at the fastest enabled setting with a fresh dwell, which catches a design that resumes where it stopped or keeps a stale count.

// File: rtl/rate_search_pkg.sv
package rate_search_pkg;
  typedef enum logic [1:0] {
    SRCH_IDLE = 2'd0,
    SRCH_RUN  = 2'd1,
    SRCH_HOLD = 2'd2
  } srch_state_e;
endpackage

// File: rtl/rate_pick.sv
// Combinational choice of the first and the following candidate index.
module rate_pick #(
  parameter int NUM_RATES = 8,
  localparam int IDX_W = $clog2(NUM_RATES)
) (
  input  logic [NUM_RATES-1:0] en,
  input  logic [IDX_W-1:0]     cur,
  output logic [IDX_W-1:0]     top_idx,
  output logic [IDX_W-1:0]     next_idx,
  output logic                 any_en
);
  logic found;

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (en[i]) top_idx = IDX_W'(i);
    end
  end

  always_comb begin
    next_idx = top_idx;
    found    = 1'b0;
    for (int i = NUM_RATES - 1; i >= 0; i--) begin
      if (!found && (i < int'(cur)) && en[i]) begin
        next_idx = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end

  assign any_en = |en;

  // R5
  always_comb begin
    if (any_en) next_in_mask_chk : assert (en[next_idx]);
  end
endmodule

// File: rtl/dwell_timer.sv
// Prescaler plus tick counter; expire marks the last cycle of a dwell.
module dwell_timer #(
  parameter int PRE_W = 10,
  parameter int IVL_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             run,
  input  logic [IVL_W-1:0] ivl,
  output logic             expire
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [IVL_W-1:0] cnt_q, cnt_d;
  logic             pre_wrap;

  assign pre_wrap = &pre_q;
  assign expire   = run && pre_wrap && (({1'b0, cnt_q} + 1'b1) >= {1'b0, ivl});

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (reload) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (run) begin
      pre_d = pre_q + 1'b1;
      if (pre_wrap) cnt_d = expire ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  // R4
  cnt_in_range_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(ivl) && ivl != '0) |-> (cnt_q < ivl));
endmodule

// File: rtl/rate_search_seq.sv
module rate_search_seq
  import rate_search_pkg::*;
#(
  parameter int NUM_RATES = 8,
  parameter int HI_W      = 5,
  parameter int LO_W      = 16,
  parameter int PRE_W     = 10,
  parameter int SEL_W     = 2,
  localparam int IDX_W    = $clog2(NUM_RATES),
  localparam int IVL_W    = HI_W + LO_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NUM_RATES-1:0] rate_en,
  input  logic [HI_W-1:0]      ivl_hi,
  input  logic [LO_W-1:0]      ivl_lo,
  input  logic [SEL_W-1:0]     ref_sel_in,
  input  logic                 lock_in,
  output logic [SEL_W-1:0]     ref_sel_out,
  output logic [IDX_W-1:0]     rate_idx,
  output logic                 searching,
  output logic                 locked
);
  srch_state_e      st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] top_idx, next_idx;
  logic             any_en, reload, expire;

  rate_pick #(.NUM_RATES(NUM_RATES)) u_pick (
    .en(rate_en), .cur(idx_q), .top_idx(top_idx),
    .next_idx(next_idx), .any_en(any_en)
  );

  dwell_timer #(.PRE_W(PRE_W), .IVL_W(IVL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .reload(reload),
    .run(st_q == SRCH_RUN), .ivl({ivl_hi, ivl_lo}), .expire(expire)
  );

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    reload = 1'b0;
    unique case (st_q)
      SRCH_IDLE: begin
        if (start && any_en) begin
          st_d   = SRCH_RUN;
          idx_d  = top_idx;
          reload = 1'b1;
        end
      end
      SRCH_RUN: begin
        if (!any_en) begin
          st_d  = SRCH_IDLE;
          idx_d = '0;
        end else if (lock_in) begin
          st_d = SRCH_HOLD;
        end else if (expire) begin
          idx_d  = next_idx;
          reload = 1'b1;
        end
      end
      SRCH_HOLD: begin
        if (!any_en) begin
          st_d  = SRCH_IDLE;
          idx_d = '0;
        end else if (!lock_in) begin
          st_d   = SRCH_RUN;
          idx_d  = top_idx;
          reload = 1'b1;
        end
      end
      default: begin
        st_d  = SRCH_IDLE;
        idx_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SRCH_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign ref_sel_out = ref_sel_in;
  assign rate_idx    = idx_q;
  assign searching   = (st_q == SRCH_RUN);
  assign locked      = (st_q == SRCH_HOLD);

  // R2
  start_go_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SRCH_IDLE && start && |rate_en) |=> searching);
  // R3
  idle_stay_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SRCH_IDLE && !(start && |rate_en)) |=> (!searching && !locked));
  // R5
  step_moves_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (searching && !lock_in && expire && |rate_en) |=>
      (rate_idx != $past(rate_idx)) || ($countones($past(rate_en)) == 1));
  // R7
  lock_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
    ((searching || locked) && lock_in && |rate_en) |=> (locked && $stable(rate_idx)));
  // R8
  lock_lost_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !lock_in && |rate_en) |=> searching);
endmodule

// File: tb/test_rate_search_seq.sv
module test_rate_search_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  rate_en;
  logic [4:0]  ivl_hi;
  logic [15:0] ivl_lo;
  logic [1:0]  ref_sel_in;
  logic        lock_in;
  logic [1:0]  ref_sel_out;
  logic [2:0]  rate_idx;
  logic        searching, locked;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // scoreboard queues: expected index, expected dwell (0 = not checked), tag
  int    q_idx[$];
  int    q_dw[$];
  string q_tag[$];

  always #5 clk = ~clk;

  rate_search_seq i_rate_search_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_en(rate_en),
    .ivl_hi(ivl_hi), .ivl_lo(ivl_lo), .ref_sel_in(ref_sel_in),
    .lock_in(lock_in), .ref_sel_out(ref_sel_out), .rate_idx(rate_idx),
    .searching(searching), .locked(locked)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_step(input int idx, input int dw, input string tag);
    q_idx.push_back(idx);
    q_dw.push_back(dw);
    q_tag.push_back(tag);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (q_idx.size() != 0) @(negedge clk);
  endtask

  // monitor: pops one expected step per new search setting, checks dwell length
  bit    prev_s   = 1'b0;
  int    prev_idx = 0;
  int    seg      = 0;
  int    cur_dw   = 0;
  string cur_tag  = "R4";
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_s = 1'b0;
      seg    = 0;
    end else begin
      if (searching && (!prev_s || int'(rate_idx) != prev_idx)) begin
        if (prev_s && cur_dw != 0) chk(seg == cur_dw, "R4 dwell", seg, cur_dw);
        if (q_idx.size() == 0) begin
          chk(1'b0, "R5 unexpected step", int'(rate_idx), -1);
          cur_dw = 0;
        end else begin
          int e;
          e       = q_idx.pop_front();
          cur_dw  = q_dw.pop_front();
          cur_tag = q_tag.pop_front();
          chk(int'(rate_idx) == e, cur_tag, int'(rate_idx), e);
        end
        seg = 1;
      end else if (searching) begin
        seg++;
      end
      prev_s   = searching;
      prev_idx = int'(rate_idx);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; rate_en = '0; ivl_hi = '0; ivl_lo = 16'd1;
    ref_sel_in = 2'b01; lock_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(!searching && !locked, "R1 flags in reset", {searching, locked}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!searching && !locked, "R1 flags after reset", {searching, locked}, 0);
    chk(rate_idx == 3'd0, "R1 index after reset", int'(rate_idx), 0);

    // R9 pass-through of every code
    for (int c = 0; c < 4; c++) begin
      ref_sel_in = 2'(c);
      #1;
      chk(ref_sel_out == 2'(c), "R9 ref select", int'(ref_sel_out), c);
    end
    ref_sel_in = 2'b01;

    // R3 empty mask ignores start
    @(negedge clk);
    pulse_start();
    repeat (4) begin
      chk(!searching && !locked, "R3 empty mask idle", {searching, locked}, 0);
      @(negedge clk);
    end

    // R5 skip + R6 wrap, interval 1
    rate_en = 8'b1010_0100; ivl_hi = '0; ivl_lo = 16'd1;
    expect_step(7, 1024, "R2 first index");
    expect_step(5, 1024, "R5 skip to 5");
    expect_step(2, 1024, "R5 skip to 2");
    expect_step(7, 1024, "R6 wrap to 7");
    expect_step(5, 0,    "R5 after wrap");
    pulse_start();
    drain();
    repeat (10) @(negedge clk);
    rate_en = '0;
    @(negedge clk);
    chk(!searching && !locked, "R3 clear mask while searching", {searching, locked}, 0);

    // R4 zero interval acts as one
    rate_en = 8'b0000_0011; ivl_lo = 16'd0;
    expect_step(1, 1024, "R2 first index");
    expect_step(0, 1024, "R4 zero interval");
    expect_step(1, 0,    "R6 wrap to 1");
    pulse_start();
    drain();
    rate_en = '0;
    @(negedge clk);

    // R4 upper interval bits honoured: no timeout within 5000 cycles
    rate_en = 8'b0000_1100; ivl_hi = 5'd1; ivl_lo = 16'd0;
    expect_step(3, 0, "R2 first index");
    pulse_start();
    repeat (5000) @(negedge clk);
    chk(searching && rate_idx == 3'd3, "R4 upper bits hold", int'(rate_idx), 3);
    rate_en = '0;
    @(negedge clk);
    chk(!searching && !locked, "R3 clear mask", {searching, locked}, 0);

    // R7 lock and R8 loss of lock, interval 2
    ivl_hi = '0; ivl_lo = 16'd2; rate_en = 8'b1000_0001;
    expect_step(7, 2048, "R2 first index");
    expect_step(0, 0,    "R5 down to 0");
    pulse_start();
    drain();
    repeat (100) @(negedge clk);
    lock_in = 1'b1;
    @(negedge clk);
    chk(locked && !searching, "R7 locked flag", {searching, locked}, 1);
    chk(rate_idx == 3'd0, "R7 index held", int'(rate_idx), 0);
    repeat (3000) @(negedge clk);
    chk(locked && rate_idx == 3'd0, "R7 lock kept past dwell", int'(rate_idx), 0);
    expect_step(7, 2048, "R8 restart at top");
    expect_step(0, 0,    "R8 next after restart");
    lock_in = 1'b0;
    @(negedge clk);
    chk(searching && !locked, "R8 search resumes", {searching, locked}, 2);
    drain();
    rate_en = '0;
    @(negedge clk);
    chk(!searching && !locked, "R3 clear mask after relock", {searching, locked}, 0);

    chk(q_idx.size() == 0, "R5 scoreboard empty", q_idx.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule